// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table held in memory. It sits behind a translation cache and runs only when that cache misses. A virtual address splits three ways: the upper 10 bits select an entry in the directory, the middle 10 bits select an entry in the second-level table that the directory entry points to, and the low 12 bits are the byte offset inside a 4 KB page. The walk therefore needs two dependent memory reads. The second read cannot start until the first returns.

The walker holds a writable base register that locates the directory. Software rewrites it when the running process changes. The walker copies the register into a private snapshot when it accepts a request, so a rewrite in the middle of a walk cannot corrupt that walk. Every table entry is one 32-bit word. Bit 0 of the entry is the present flag, and bits 31:12 hold the frame number or the base of the next table. If a present flag is clear, the walk stops and the walker returns a fault that names the failing level.

All three data paths use valid/ready handshakes. On the request side, `req_ready` is high only while the walker is idle, and a request transfers on the clock edge where `req_valid` and `req_ready` are both high. The memory read port sends a request that must stay valid, with a stable address, until the memory raises `mem_req_ready`. The memory returns one `mem_rsp_valid` pulse per read. The walker is always ready for that response, so the response side has no ready pin. On the result side, all result fields stay stable until `res_ready` is seen high.

Top module: `xlat_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0 and `mem_req_valid` is 0.
- R2: The first memory read of a walk is at address base + vaddr[31:22] × 4. The base used is the register value when the request is accepted.
- R3: When the directory entry has bit 0 set, the second read is at address {dir_entry[31:12], 12'h000} + vaddr[21:12] × 4.
- R4: When both entries have bit 0 set, the result has `res_fault` = 0 and `res_paddr` = {table_entry[31:12], vaddr[11:0]}. Entry bits 11:1 are ignored, and exactly two memory reads are made.
- R5: A directory entry with bit 0 clear ends the walk after one read. The result then has `res_fault` = 1, `res_fault_lvl` = 0 and `res_paddr` = 0.
- R6: A table entry with bit 0 clear ends the walk after two reads. The result then has `res_fault` = 1, `res_fault_lvl` = 1 and `res_paddr` = 0.
- R7: `res_vaddr` always returns the virtual address of the request being answered. `req_ready` stays low from the accepting edge until the result handshake.
- R8: A memory read request holds its valid and its address until it is accepted. Only one read is outstanding at a time.
- R9: While `res_valid` is high and `res_ready` is low, every result output holds its value.
- R10: A base write made during a walk, or on the same edge that a request is accepted, does not affect that walk. It applies to the next request accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_wr | input | 1 | Write strobe for the directory base register |
| base_wdata | input | 32 | New directory base value |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Read data pulse, one per accepted read |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Translation result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_paddr | output | 32 | Physical address, 0 on a fault |
| res_fault | output | 1 | Walk ended on a clear present flag |
| res_fault_lvl | output | 1 | Failing level: 0 directory, 1 table |
| res_vaddr | output | 32 | Virtual address of this result |

## Verification
The hardest case to reach is a base-register rewrite that lands while a walk is in flight, or on the very edge where a request is accepted. That walk must still use the old directory, and the next walk must use the new one. To reach it, the bench stretches memory latency and stalls `mem_req_ready`, so each walk spans many cycles. It then forks the base write alongside the request, once a few cycles after acceptance and once in the same cycle. The expected read addresses and the expected result are both worked out from the base value the bench's own model held when the request was accepted.

// File: rtl/xw_pkg.sv
package xw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_DIR,
    S_WT_DIR,
    S_RD_TBL,
    S_WT_TBL,
    S_DONE
  } walk_st_t;

  localparam logic LVL_DIR = 1'b0;
  localparam logic LVL_TBL = 1'b1;
endpackage

// File: rtl/xw_base_reg.sv
module xw_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) base_q <= '0;
    else if (wr) base_q <= wdata;
  end

  // R10
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(base_q));
endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int DIR_W = 10
) (
  input  logic          sel_tbl,
  input  logic [AW-1:0] dir_base,
  input  logic [AW-1:0] tbl_base,
  input  logic [AW-1:0] vaddr,
  output logic [AW-1:0] rd_addr
);
  localparam int TBL_W  = AW - OFF_W - DIR_W;
  localparam int IDX_SH = $clog2(AW / 8);

  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [AW-1:0]    dir_off;
  logic [AW-1:0]    tbl_off;

  assign dir_idx = vaddr[AW-1 -: DIR_W];
  assign tbl_idx = vaddr[OFF_W +: TBL_W];
  assign dir_off = {{(AW-DIR_W-IDX_SH){1'b0}}, dir_idx, {IDX_SH{1'b0}}};
  assign tbl_off = {{(AW-TBL_W-IDX_SH){1'b0}}, tbl_idx, {IDX_SH{1'b0}}};

  always_comb begin
    if (sel_tbl) rd_addr = tbl_base + tbl_off;
    else         rd_addr = dir_base + dir_off;
  end
endmodule

// File: rtl/xw_walk_fsm.sv
module xw_walk_fsm
  import xw_pkg::*;
#(
  parameter int AW    = 32,
  parameter int OFF_W = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] base_q,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          sel_tbl,
  output logic [AW-1:0] dir_base,
  output logic [AW-1:0] tbl_base,
  output logic [AW-1:0] vaddr,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_paddr,
  output logic          res_fault,
  output logic          res_fault_lvl
);
  localparam int FRM_W = AW - OFF_W;

  walk_st_t       st;
  logic [AW-1:0]  vaddr_q;
  logic [AW-1:0]  snap_q;
  logic [AW-1:0]  tbase_q;
  logic [AW-1:0]  paddr_q;
  logic           fault_q;
  logic           lvl_q;
  logic           present;
  logic [FRM_W-1:0] frame;

  assign present = mem_rsp_data[0];
  assign frame   = mem_rsp_data[AW-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vaddr_q <= '0;
      snap_q  <= '0;
      tbase_q <= '0;
      paddr_q <= '0;
      fault_q <= 1'b0;
      lvl_q   <= LVL_DIR;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          snap_q  <= base_q;
          st      <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_req_ready) st <= S_WT_DIR;
        S_WT_DIR: if (mem_rsp_valid) begin
          if (!present) begin
            fault_q <= 1'b1;
            lvl_q   <= LVL_DIR;
            paddr_q <= '0;
            st      <= S_DONE;
          end else begin
            tbase_q <= {frame, {OFF_W{1'b0}}};
            st      <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_req_ready) st <= S_WT_TBL;
        S_WT_TBL: if (mem_rsp_valid) begin
          lvl_q <= LVL_TBL;
          st    <= S_DONE;
          if (!present) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
          end else begin
            fault_q <= 1'b0;
            paddr_q <= {frame, vaddr_q[OFF_W-1:0]};
          end
        end
        S_DONE: if (res_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == S_IDLE);
  assign mem_req_valid = (st == S_RD_DIR) || (st == S_RD_TBL);
  assign sel_tbl       = (st == S_RD_TBL);
  assign res_valid     = (st == S_DONE);
  assign dir_base      = snap_q;
  assign tbl_base      = tbase_q;
  assign vaddr         = vaddr_q;
  assign res_paddr     = paddr_q;
  assign res_fault     = fault_q;
  assign res_fault_lvl = lvl_q;

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) &&
    $stable(res_fault) && $stable(res_fault_lvl) && $stable(vaddr_q));

  // R8
  one_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R7
  idle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid);

  // R10
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |=> $stable(snap_q));
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int AW    = 32,
  parameter int OFF_W = 12,
  parameter int DIR_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_wdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_paddr,
  output logic          res_fault,
  output logic          res_fault_lvl,
  output logic [AW-1:0] res_vaddr
);
  logic [AW-1:0] base_q;
  logic [AW-1:0] dir_base;
  logic [AW-1:0] tbl_base;
  logic [AW-1:0] vaddr;
  logic          sel_tbl;

  xw_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .wr(base_wr), .wdata(base_wdata), .base_q(base_q)
  );

  xw_walk_fsm #(.AW(AW), .OFF_W(OFF_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .base_q(base_q),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .sel_tbl(sel_tbl), .dir_base(dir_base), .tbl_base(tbl_base), .vaddr(vaddr),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_fault_lvl(res_fault_lvl)
  );

  xw_addr_gen #(.AW(AW), .OFF_W(OFF_W), .DIR_W(DIR_W)) u_addr (
    .sel_tbl(sel_tbl), .dir_base(dir_base), .tbl_base(tbl_base),
    .vaddr(vaddr), .rd_addr(mem_req_addr)
  );

  assign res_vaddr = vaddr;

  // R4
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_fault |-> res_paddr[OFF_W-1:0] == res_vaddr[OFF_W-1:0]);

  // R8
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
endmodule

// File: tb/sim_xlat_walker.sv
module sim_xlat_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_fault_lvl;
  logic [31:0] res_vaddr;

  always #2.5 clk = ~clk;

  xlat_walker u0 (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_fault(res_fault), .res_fault_lvl(res_fault_lvl),
    .res_vaddr(res_vaddr)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mem [bit [31:0]];
  logic [31:0] model_base = '0;
  logic [31:0] exp_addr_q [$];
  logic [31:0] exp_pa_q [$];
  logic        exp_flt_q [$];
  logic        exp_lvl_q [$];
  logic [31:0] exp_va_q [$];
  int          rd_count = 0;
  bit          running = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mkva(input int d, input int t, input int o);
    return {d[9:0], t[9:0], o[11:0]};
  endfunction

  task automatic predict(input logic [31:0] va);
    logic [31:0] da, de, ta, te;
    da = model_base + {20'b0, va[31:22], 2'b00};
    de = rd(da);
    exp_addr_q.push_back(da);
    exp_va_q.push_back(va);
    if (!de[0]) begin
      exp_flt_q.push_back(1'b1); exp_lvl_q.push_back(1'b0); exp_pa_q.push_back(32'h0);
    end else begin
      ta = {de[31:12], 12'h0} + {20'b0, va[21:12], 2'b00};
      te = rd(ta);
      exp_addr_q.push_back(ta);
      exp_lvl_q.push_back(1'b1);
      if (!te[0]) begin
        exp_flt_q.push_back(1'b1); exp_pa_q.push_back(32'h0);
      end else begin
        exp_flt_q.push_back(1'b0); exp_pa_q.push_back({te[31:12], va[11:0]});
      end
    end
  endtask

  task automatic send(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    predict(va);
    @(negedge clk);
    req_valid = 1'b0;
    // R7: busy after acceptance
    chk(req_ready == 1'b0, "R7 req_ready after accept", {31'b0, req_ready}, 32'h0);
  endtask

  task automatic wr_base(input logic [31:0] v);
    @(negedge clk);
    base_wr = 1'b1;
    base_wdata = v;
    @(posedge clk);
    model_base = v;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  task automatic drain();
    while (exp_va_q.size() != 0) @(negedge clk);
    while (!req_ready) @(negedge clk);
  endtask

  // memory responder: checks read addresses (R2, R3, R8)
  initial begin
    int pat = 0;
    int lat;
    logic [31:0] d;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      pat++;
      mem_req_ready = (pat % 3) != 0;
      if (mem_req_valid && mem_req_ready) begin
        rd_count++;
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R8 unexpected memory read", mem_req_addr, 32'h0);
          d = 32'h0;
        end else begin
          logic [31:0] ea;
          ea = exp_addr_q.pop_front();
          chk(mem_req_addr == ea, "R2/R3 read address", mem_req_addr, ea);
          d = rd(mem_req_addr);
        end
        lat = pat % 4;
        @(negedge clk);
        mem_req_ready = 1'b0;
        // R8: no second read while one is outstanding
        chk(mem_req_valid == 1'b0, "R8 single outstanding", {31'b0, mem_req_valid}, 32'h0);
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data = d;
      end
    end
  end

  // result monitor / scoreboard (R4, R5, R6, R7, R9)
  initial begin
    int pat = 0;
    bit held = 1'b0;
    logic [31:0] h_pa, h_va;
    logic h_f, h_l;
    forever begin
      @(negedge clk);
      if (held) begin
        chk(res_valid && res_paddr == h_pa && res_vaddr == h_va &&
            res_fault == h_f && res_fault_lvl == h_l, "R9 result held",
            res_paddr, h_pa);
      end
      pat++;
      res_ready = (pat % 5) > 1;
      held = 1'b0;
      if (res_valid && !res_ready) begin
        held = 1'b1; h_pa = res_paddr; h_va = res_vaddr; h_f = res_fault; h_l = res_fault_lvl;
      end
      if (res_valid && res_ready) begin
        if (exp_va_q.size() == 0) begin
          chk(1'b0, "R7 unexpected result", res_vaddr, 32'h0);
        end else begin
          logic [31:0] ep, ev;
          logic ef, el;
          ep = exp_pa_q.pop_front(); ev = exp_va_q.pop_front();
          ef = exp_flt_q.pop_front(); el = exp_lvl_q.pop_front();
          chk(res_vaddr == ev, "R7 res_vaddr", res_vaddr, ev);
          chk(res_fault == ef, ef ? "R5/R6 fault flag" : "R4 fault flag",
              {31'b0, res_fault}, {31'b0, ef});
          if (ef) chk(res_fault_lvl == el, el ? "R6 fault level" : "R5 fault level",
                      {31'b0, res_fault_lvl}, {31'b0, el});
          chk(res_paddr == ep, ef ? "R5/R6 paddr zero" : "R4 paddr", res_paddr, ep);
          chk(exp_addr_q.size() == 0, "R4/R5/R6 read count",
              exp_addr_q.size(), 32'h0);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (running) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // directory A
    mem[32'h0010_0000 + 4*1]     = 32'h0030_0001;
    mem[32'h0010_0000 + 4*2]     = 32'h0040_0000;
    mem[32'h0010_0000 + 4*1023]  = 32'h0050_0001;
    mem[32'h0030_0000 + 4*5]     = 32'hABCD_E001;
    mem[32'h0030_0000 + 4*6]     = 32'h1234_5000;
    mem[32'h0030_0000 + 4*1023]  = 32'hFFFF_F001;
    mem[32'h0050_0000]           = 32'h0000_1FFF;
    // directory B
    mem[32'h0020_0000 + 4*1]     = 32'h0060_0001;
    mem[32'h0060_0000 + 4*5]     = 32'h7777_7003;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready", {31'b0, req_ready}, 32'h1);
    chk(res_valid == 1'b0, "R1 res_valid", {31'b0, res_valid}, 32'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", {31'b0, mem_req_valid}, 32'h0);
    rst_n = 1'b1;

    wr_base(32'h0010_0000);
    send(mkva(1, 5, 12'h123));      // R4
    send(mkva(1, 5, 12'hFFF));      // R4 top offset
    send(mkva(1, 6, 0));            // R6 table entry absent
    send(mkva(2, 0, 12'h010));      // R5 directory entry absent
    send(mkva(1023, 0, 12'h777));   // R2 last directory slot, R4 ignored bits
    send(mkva(1, 1023, 0));         // R3 last table slot
    send(mkva(0, 0, 0));            // R5 empty slot
    drain();

    // R10: base rewrite during a walk
    fork
      send(mkva(1, 5, 12'h456));
      begin
        repeat (3) @(negedge clk);
        wr_base(32'h0020_0000);
      end
    join
    drain();
    send(mkva(1, 5, 12'h456));      // R10 new base in force
    drain();

    // R10: rewrite on the accepting edge
    fork
      send(mkva(1, 5, 12'h00A));
      wr_base(32'h0010_0000);
    join
    drain();
    send(mkva(1, 5, 12'h00B));      // R10 restored base
    drain();

    // back-to-back burst
    for (int i = 0; i < 6; i++) send(mkva((i % 2) ? 1 : 2, 5 + (i % 2), i * 16));
    drain();
    repeat (10) @(negedge clk);

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule